// File: doc/BRIEF.md
# Configuration Port Bridge with Memory Routing

This block sits on the host side of a peripheral interconnect. Software reaches the configuration registers of downstream devices indirectly. It first writes a selector word to one I/O port, which names a bus, a device, a function and a dword register. It then reads or writes a second I/O port, and the bridge turns that access into a configuration cycle on the register the selector names. Only the addressed device takes part. Neither port is ever passed on to main memory.

Each modelled device holds a base-address register. Once software has programmed it, later memory accesses are steered by address. Addresses below the installed-memory limit always go to RAM, even when a device window overlaps them. Above that limit, a device claims an access whose address falls inside its window. Anything left unclaimed goes down the default path by subtractive decoding. Every host request gets exactly one response, and that response carries a tag naming where the access went.

Top module: `cfg_bridge`

## Requirements
- R1: An I/O write to address 0x0CF8 stores its data masked with 0x80FF_FFFC as the selector. An I/O read of 0x0CF8 returns the stored selector, which is zero after reset. Selector fields: bit 31 enable, bits 23:16 bus, 15:11 device, 10:8 function, 7:2 dword index.
- R2: With enable set, bus 0, function 0 and device number below NUM_DEV, an I/O read of 0x0CFC returns that device's register. Index 0 reads 0xC0DE_0000 plus the device number. Index 4 (offset 0x10) reads the base register. Every other index reads zero.
- R3: An I/O write of 0x0CFC at index 4 of an existing device sets its base register to the written data with the low WIN_BITS bits cleared. Writes to other indices have no effect.
- R4: With the selector's enable bit clear, an I/O read of 0x0CFC returns 0xFFFF_FFFF and an I/O write of 0x0CFC changes no register.
- R5: A 0x0CFC access naming a non-zero bus, a non-zero function or a device number of NUM_DEV or more reads 0xFFFF_FFFF, and a write to it is dropped.
- R6: Responses to accesses of 0x0CF8 and 0x0CFC carry target tag 2 (configuration), never the RAM tag.
- R7: A memory access below MEM_LIMIT gets tag 0 (RAM), even when a device base matches the address.
- R8: A memory access at or above MEM_LIMIT whose bits 31:WIN_BITS equal those of device n's base gets tag 3+n. When windows overlap, the lowest device number wins.
- R9: A memory access at or above MEM_LIMIT that no device claims gets tag 1 (subtractive). An I/O access to any other port also gets tag 1, and a read of such a port returns 0xFFFF_FFFF. Memory responses return zero data.
- R10: A request is accepted when req_valid and req_ready are both high. Its response is valid on the next cycle. req_ready stays low while a response is pending, and the response stays unchanged until rsp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read data |
| rsp_target | output | TAG_W | Target tag: 0 RAM, 1 subtractive, 2 configuration, 3+n device n |

## Verification
Every response becomes valid on the clock edge after the edge that accepts its request. The bench releases req_valid at the falling edge after acceptance and samples rsp_valid, rsp_rdata and rsp_target at that same falling edge. A base or selector write takes effect on its accepting edge, so the very next request already sees the new value, and the checks rely on that. For the stall case the bench holds rsp_ready low and checks at several later falling edges that the response and the low req_ready have not changed. It then checks that the response is gone one edge after rsp_ready rises.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam logic [31:0] SEL_PORT  = 32'h0000_0CF8;
  localparam logic [31:0] DAT_PORT  = 32'h0000_0CFC;
  localparam logic [31:0] SEL_MASK  = 32'h80FF_FFFC;
  localparam logic [31:0] ID_BASE   = 32'hC0DE_0000;
  localparam logic [5:0]  IDX_ID    = 6'd0;
  localparam logic [5:0]  IDX_BASE  = 6'd4;
  localparam int          TAG_RAM   = 0;
  localparam int          TAG_SUB   = 1;
  localparam int          TAG_CFG   = 2;
  localparam int          TAG_DEV0  = 3;

  typedef struct packed {
    logic       en;
    logic [6:0] rsvd;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] idx;
    logic [1:0] zero;
  } sel_t;
endpackage

// File: rtl/cfgb_dev.sv
module cfgb_dev
  import cfgb_pkg::*;
#(
  parameter int DEV_NUM  = 0,
  parameter int WIN_BITS = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [5:0]  idx,
  input  logic [31:0] wdata,
  output logic [31:0] base_q,
  output logic [31:0] rdata
);
  localparam logic [31:0] BASE_MASK = ~((32'd1 << WIN_BITS) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (wr_en && idx == IDX_BASE) begin
      base_q <= wdata & BASE_MASK;
    end
  end

  always_comb begin
    case (idx)
      IDX_ID:   rdata = ID_BASE + 32'(DEV_NUM);
      IDX_BASE: rdata = base_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfgb_decode.sv
module cfgb_decode
  import cfgb_pkg::*;
#(
  parameter int          NUM_DEV   = 3,
  parameter logic [31:0] MEM_LIMIT = 32'h4000_0000,
  parameter int          WIN_BITS  = 12,
  parameter int          TAG_W     = 3
) (
  input  logic [31:0]              addr,
  input  logic [NUM_DEV-1:0][31:0] bases,
  output logic [TAG_W-1:0]         tag
);
  logic [NUM_DEV-1:0] hit;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cmp
    assign hit[g] = (addr[31:WIN_BITS] == bases[g][31:WIN_BITS]);
  end

  always_comb begin
    tag = TAG_W'(TAG_SUB);
    if (addr < MEM_LIMIT) begin
      tag = TAG_W'(TAG_RAM);
    end else begin
      for (int i = NUM_DEV - 1; i >= 0; i--) begin
        if (hit[i]) tag = TAG_W'(TAG_DEV0 + i);
      end
    end
  end
endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
  import cfgb_pkg::*;
#(
  parameter int          NUM_DEV   = 3,
  parameter logic [31:0] MEM_LIMIT = 32'h4000_0000,
  parameter int          WIN_BITS  = 12,
  localparam int         TAG_W     = $clog2(NUM_DEV + TAG_DEV0)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_io,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic [TAG_W-1:0] rsp_target
);
  sel_t                     sel_q;
  logic                     acc, is_sel, is_dat, dev_ok;
  logic [NUM_DEV-1:0]       dev_we;
  logic [NUM_DEV-1:0][31:0] bases;
  logic [NUM_DEV-1:0][31:0] dev_rd;
  logic [31:0]              cfg_rd;
  logic [TAG_W-1:0]         mem_tag;

  assign req_ready = !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign is_sel    = req_io && (req_addr == SEL_PORT);
  assign is_dat    = req_io && (req_addr == DAT_PORT);
  assign dev_ok    = sel_q.en && (sel_q.bus == 8'd0) && (sel_q.fn == 3'd0) &&
                     (32'(sel_q.dev) < NUM_DEV);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (acc && is_sel && req_write) begin
      sel_q <= sel_t'(req_wdata & SEL_MASK);
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign dev_we[g] = acc && is_dat && req_write && dev_ok && (32'(sel_q.dev) == g);
    cfgb_dev #(.DEV_NUM(g), .WIN_BITS(WIN_BITS)) u_dev (
      .clk   (clk),
      .rst   (rst),
      .wr_en (dev_we[g]),
      .idx   (sel_q.idx),
      .wdata (req_wdata),
      .base_q(bases[g]),
      .rdata (dev_rd[g])
    );
  end

  always_comb begin
    cfg_rd = '1;
    if (dev_ok) begin
      for (int i = 0; i < NUM_DEV; i++) begin
        if (32'(sel_q.dev) == i) cfg_rd = dev_rd[i];
      end
    end
  end

  cfgb_decode #(
    .NUM_DEV(NUM_DEV), .MEM_LIMIT(MEM_LIMIT), .WIN_BITS(WIN_BITS), .TAG_W(TAG_W)
  ) u_dec (
    .addr (req_addr),
    .bases(bases),
    .tag  (mem_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_target <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      if (!req_io) begin
        rsp_rdata  <= '0;
        rsp_target <= mem_tag;
      end else if (is_sel) begin
        rsp_rdata  <= req_write ? 32'd0 : 32'(sel_q);
        rsp_target <= TAG_W'(TAG_CFG);
      end else if (is_dat) begin
        rsp_rdata  <= req_write ? 32'd0 : cfg_rd;
        rsp_target <= TAG_W'(TAG_CFG);
      end else begin
        rsp_rdata  <= req_write ? 32'd0 : 32'hFFFF_FFFF;
        rsp_target <= TAG_W'(TAG_SUB);
      end
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker
  import cfgb_pkg::*;
#(
  parameter logic [31:0] MEM_LIMIT = 32'h4000_0000,
  parameter int          TAG_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_io,
  input logic             req_write,
  input logic [31:0]      req_addr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic [TAG_W-1:0] rsp_target,
  input logic             sel_en
);
  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);

  assert_no_accept_pending_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_target));

  assert_ram_first_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !req_io && req_addr < MEM_LIMIT |=> rsp_target == TAG_W'(TAG_RAM));

  assert_port_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_io && (req_addr == SEL_PORT || req_addr == DAT_PORT)
    |=> rsp_target == TAG_W'(TAG_CFG));

  assert_disabled_ones_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_io && !req_write && req_addr == DAT_PORT && !sel_en
    |=> rsp_rdata == 32'hFFFF_FFFF);
endmodule

bind cfg_bridge cfgb_checker #(.MEM_LIMIT(MEM_LIMIT), .TAG_W(TAG_W)) u_cfgb_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_io    (req_io),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_target(rsp_target),
  .sel_en    (sel_q.en)
);

// File: tb/test_cfg_bridge.sv
module test_cfg_bridge;
  localparam int          NDEV  = 3;
  localparam logic [31:0] LIM   = 32'h4000_0000;
  localparam int          WB    = 12;
  localparam int          TW    = $clog2(NDEV + 3);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0;
  logic [31:0]   req_addr = '0, req_wdata = '0;
  logic          rsp_ready = 1'b1;
  logic          req_ready, rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [TW-1:0] rsp_target;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] sel_m;
  logic [31:0] base_m [NDEV];

  always #4 clk = ~clk;

  cfg_bridge #(.NUM_DEV(NDEV), .MEM_LIMIT(LIM), .WIN_BITS(WB)) i_cfg_bridge (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_io(req_io),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_target(rsp_target)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit sel_ok(input logic [31:0] s);
    return s[31] && s[23:16] == 8'd0 && s[10:8] == 3'd0 && int'(s[15:11]) < NDEV;
  endfunction

  function automatic logic [31:0] exp_cfg(input logic [31:0] s);
    if (!sel_ok(s)) return 32'hFFFF_FFFF;
    if (s[7:2] == 6'd0) return 32'hC0DE_0000 + 32'(s[15:11]);
    if (s[7:2] == 6'd4) return base_m[s[15:11]];
    return 32'd0;
  endfunction

  function automatic logic [TW-1:0] exp_tag(input logic [31:0] a);
    if (a < LIM) return TW'(0);
    for (int i = 0; i < NDEV; i++)
      if (a[31:WB] == base_m[i][31:WB]) return TW'(3 + i);
    return TW'(1);
  endfunction

  task automatic xfer(input bit io, input bit wr, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic [TW-1:0] tg);
    @(negedge clk);
    req_valid = 1'b1; req_io = io; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10", "response one cycle after accept", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata; tg = rsp_target;
    @(posedge clk);
  endtask

  task automatic sel_wr(input logic [31:0] d);
    logic [31:0] rd; logic [TW-1:0] tg;
    xfer(1'b1, 1'b1, 32'h0CF8, d, rd, tg);
    sel_m = d & 32'h80FF_FFFC;
    chk(tg == TW'(2), "R6", "selector write tag", 32'(tg), 32'd2);
  endtask

  task automatic sel_rd();
    logic [31:0] rd; logic [TW-1:0] tg;
    xfer(1'b1, 1'b0, 32'h0CF8, 32'd0, rd, tg);
    chk(rd == sel_m, "R1", "selector readback", rd, sel_m);
  endtask

  task automatic dat_wr(input logic [31:0] d);
    logic [31:0] rd; logic [TW-1:0] tg;
    xfer(1'b1, 1'b1, 32'h0CFC, d, rd, tg);
    if (sel_ok(sel_m) && sel_m[7:2] == 6'd4)
      base_m[sel_m[15:11]] = d & ~((32'd1 << WB) - 32'd1);
    chk(tg == TW'(2), "R6", "data write tag", 32'(tg), 32'd2);
  endtask

  task automatic dat_rd(input string req);
    logic [31:0] rd; logic [TW-1:0] tg;
    xfer(1'b1, 1'b0, 32'h0CFC, 32'd0, rd, tg);
    chk(rd == exp_cfg(sel_m), req, "config read", rd, exp_cfg(sel_m));
    chk(tg == TW'(2), "R6", "data read tag", 32'(tg), 32'd2);
  endtask

  task automatic mem(input string req, input logic [31:0] a);
    logic [31:0] rd; logic [TW-1:0] tg;
    xfer(1'b0, 1'($urandom_range(0, 1)), a, $urandom, rd, tg);
    chk(tg == exp_tag(a), req, "memory target", 32'(tg), 32'(exp_tag(a)));
    chk(rd == 32'd0, "R9", "memory data", rd, 32'd0);
  endtask

  task automatic set_base(input int n, input logic [31:0] v);
    sel_wr(32'h8000_0010 | (32'(n) << 11));
    dat_wr(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, held; logic [TW-1:0] tg;
    void'($urandom(32'd2024));
    sel_m = '0;
    for (int i = 0; i < NDEV; i++) base_m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R10", "reset req_ready", 32'(req_ready), 32'd1);
    sel_rd();                                   // R1 reset value

    sel_wr(32'hFFFF_FFFF); sel_rd();            // R1 mask
    sel_wr(32'h8000_0800); dat_rd("R2");        // R2 ID of device 1
    set_base(1, 32'h8888_8ABC);                 // R3
    dat_rd("R3");
    sel_wr(32'h8000_0804); dat_wr(32'h1234_5678); dat_rd("R3"); // index 1 write ignored
    mem("R8", 32'h8888_8FFF);
    mem("R8", 32'h8888_7FFF);
    set_base(2, 32'h8888_8000);
    mem("R8", 32'h8888_8004);                   // overlap: device 1 wins
    set_base(0, 32'h1000_0000);
    mem("R7", 32'h1000_0010);                   // RAM beats device 0
    mem("R9", 32'hF000_0000);

    sel_wr(32'h0000_1010); dat_wr(32'hDEAD_B000); dat_rd("R4");  // R4 enable clear
    sel_wr(32'h8000_1010); dat_rd("R4");
    sel_wr(32'h8001_0010); dat_wr(32'hAAAA_A000); dat_rd("R5");  // R5 bus 1
    sel_wr(32'h8000_0110); dat_rd("R5");                          // R5 function 1
    sel_wr(32'h8000_1810); dat_rd("R5");                          // R5 device 3
    for (int i = 0; i < NDEV; i++) begin
      sel_wr(32'h8000_0010 | (32'(i) << 11)); dat_rd("R5");
    end

    xfer(1'b1, 1'b0, 32'h0000_0080, 32'd0, rd, tg);
    chk(rd == 32'hFFFF_FFFF, "R9", "other port data", rd, 32'hFFFF_FFFF);
    chk(tg == TW'(1), "R9", "other port tag", 32'(tg), 32'd1);

    // R10 stall
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_io = 1'b1; req_write = 1'b0; req_addr = 32'h0CF8;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    held = rsp_rdata;
    chk(held == sel_m, "R1", "stalled selector read", held, sel_m);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R10", "held valid", 32'(rsp_valid), 32'd1);
      chk(req_ready == 1'b0, "R10", "ready low while pending", 32'(req_ready), 32'd0);
      chk(rsp_rdata == held, "R10", "held data", rsp_rdata, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "released", 32'(rsp_valid), 32'd0);

    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: sel_wr({1'($urandom_range(0, 3) != 0), 7'($urandom),
                   ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'd0,
                   5'($urandom_range(0, 4)),
                   ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'd0,
                   ($urandom_range(0, 1) == 1) ? 6'd4 : 6'($urandom_range(0, 7)),
                   2'($urandom)});
        1: dat_rd("R2");
        2: dat_wr(($urandom_range(0, 3) == 0) ? 32'($urandom) : (32'h8000_0000 | 32'($urandom)));
        3: mem("R8", base_m[$urandom_range(0, NDEV - 1)] | 32'($urandom_range(0, 4095)));
        4: mem("R9", $urandom);
        default: sel_rd();
      endcase
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule